// File: doc/BRIEF.md
# High-Speed USB Transmit Packet Framer

This block turns the outgoing byte stream of a high-speed USB link layer into the one-bit line-symbol stream sent to the analogue driver. A packet begins when the link pulses a start strobe while presenting the first byte. The framer then emits a 32-symbol synchronisation preamble and the payload, least significant bit first. The payload is NRZI-encoded with zero-insertion after long runs of ones. The packet closes with an end-of-packet run of unchanged symbols that breaks the stuffing rule on purpose. A drive-enable marks the symbols that belong to a packet. While the enable is low the line rests in its idle (SE0) state.

When the block replies to a packet it has just received, a turnaround timer holds the preamble back until a minimum idle gap has passed. It then starts at once, so the reply stays well inside the upper limit of 192 bit times. Four compliance test modes are selected with a mode input. Two of them drive a constant J or a constant K. A third sends a computed test packet over and over. The fourth, SE0_NAK, frames traffic exactly as in normal operation; the handshake responder for that mode lives outside this block. One clock cycle equals one symbol time.

Top module: `usbtx_framer`

## Requirements
- R1: The first symbols of every packet form the preamble: 15 K-J pairs and then two K, 32 symbols in all. Symbol encoding: `line_k_o`=1 is K and 0 is J. The first symbol is K, a change from the J reference held while idle.
- R2: Payload bytes are sent LSB first. A data 0 changes the line level and a data 1 keeps it. The preamble counts as data bits 0..31, with bit 31 equal to 1 and all others 0.
- R3: After STUFF_RUN (6) consecutive data ones, including the final preamble one, an extra level change is inserted and the ones count restarts. This applies across byte boundaries and also right before the end-of-packet field.
- R4: The end-of-packet field is EOP_BITS (8) symbols at the level of the last symbol, with no stuffing. If `tx_sof_i` was high with the start strobe, the field is SOF_EOP_BITS (40) symbols long.
- R5: `line_oe_o` rises with the first preamble symbol and falls right after the last end-of-packet symbol. Whenever `line_oe_o` is 0, `line_k_o` is 0. Reset forces both low at once, even in the middle of a packet.
- R6: With no turnaround pending, the first preamble symbol appears on the first rising edge after the edge that samples `tx_start_i`.
- R7: When `rx_end_i` is sampled, no preamble may start for the next GAP_MIN+1 cycles. A start that is pending during that time begins its first symbol exactly GAP_MIN+2 edges after the edge that sampled `rx_end_i`.
- R8: `tx_next_o` is a one-cycle pulse, one cycle after the framer has taken the current byte from `tx_data_i` and `tx_last_i`. It pulses once per payload byte: the first byte is taken at the end of the preamble, and each later byte when the previous byte's last bit has been sent.
- R9: Mode 2 (Test J) drives `line_oe_o`=1 and `line_k_o`=0 on every cycle from the edge after the mode is applied.
- R10: Mode 3 (Test K) drives `line_oe_o`=1 and `line_k_o`=1 on every cycle from the edge after the mode is applied.
- R11: Mode 4 (test packet) sends TP_BYTES bytes, byte k equal to 8'hA5 XOR k, with the normal preamble and an EOP_BITS end field. It repeats this packet without end, with GAP_MIN+1 idle cycles between copies, and leaves `tx_next_o` low.
- R12: Mode 1 (SE0_NAK) and mode 0 (normal) produce identical framing, timing and byte strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | 0 normal, 1 SE0_NAK, 2 Test J, 3 Test K, 4 test packet |
| rx_end_i | input | 1 | Pulse at the end of a received packet; starts the turnaround gap |
| tx_start_i | input | 1 | Start strobe for a new packet; first byte valid with it |
| tx_sof_i | input | 1 | With the start strobe: the packet takes the long end field |
| tx_data_i | input | 8 | Current payload byte, held until `tx_next_o` |
| tx_last_i | input | 1 | Current byte is the last of the packet |
| tx_next_o | output | 1 | One-cycle pulse after the current byte was taken |
| line_k_o | output | 1 | Line symbol: 1 = K, 0 = J; 0 while idle |
| line_oe_o | output | 1 | Drive enable; low means idle SE0 |

## Verification
The bench builds the framer with GAP_MIN=8, EOP_BITS=8, SOF_EOP_BITS=40 and TP_BYTES=4. The short test packet lets two copies and the gap between them be checked within a few hundred cycles. A turnaround of eight cycles keeps the exact latency of a delayed start easy to count. The 40-symbol end field exercises the start-of-frame path. Payloads of all ones, all zeros and mixed patterns place stuffed bits inside bytes, across byte boundaries and just before the end field.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL   = 3'd0,
    MODE_SE0_NAK  = 3'd1,
    MODE_TEST_J   = 3'd2,
    MODE_TEST_K   = 3'd3,
    MODE_TEST_PKT = 3'd4
  } tx_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SYNC,
    SQ_DATA,
    SQ_EOP
  } seq_state_e;

  localparam int SYNC_BITS = 32;

endpackage

// File: rtl/usbtx_gap_timer.sv
module usbtx_gap_timer #(
  parameter int GAP_MIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic gap_ok_o
);
  localparam int CW = $clog2(GAP_MIN + 1);
  localparam logic [CW-1:0] CMAX = CW'(GAP_MIN);

  logic [CW-1:0] cnt_q;

  // Saturating idle counter: restarts on a received packet end (R7)
  // or on the end of a looped test packet (R11).
  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= CMAX;
    else if (restart_i)     cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign gap_ok_o = (cnt_q == CMAX) && !restart_i;

endmodule

// File: rtl/usbtx_test_pattern.sv
module usbtx_test_pattern #(
  parameter int TP_BYTES = 16,
  localparam int TPW = (TP_BYTES > 2) ? $clog2(TP_BYTES) : 1
) (
  input  logic [TPW-1:0] idx_i,
  output logic [7:0]     byte_o,
  output logic           last_o
);
  // Computed test payload: byte k = 8'hA5 ^ k (R11)
  assign byte_o = 8'hA5 ^ 8'(idx_i);
  assign last_o = (idx_i == TPW'(TP_BYTES - 1));

endmodule

// File: rtl/usbtx_sequencer.sv
module usbtx_sequencer
  import usbtx_pkg::*;
#(
  parameter int EOP_BITS     = 8,
  parameter int SOF_EOP_BITS = 40,
  parameter int TP_BYTES     = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold_i,
  input  logic       test_pkt_i,
  input  logic       start_i,
  input  logic       sof_i,
  input  logic [7:0] data_i,
  input  logic       last_i,
  input  logic       gap_ok_i,
  input  logic       adv_i,
  output logic       bit_o,
  output logic       valid_o,
  output logic       stuff_en_o,
  output logic       next_o,
  output logic       gap_kick_o
);
  localparam int MAXB = (SOF_EOP_BITS > SYNC_BITS) ?
                        ((SOF_EOP_BITS > EOP_BITS) ? SOF_EOP_BITS : EOP_BITS) :
                        ((SYNC_BITS > EOP_BITS) ? SYNC_BITS : EOP_BITS);
  localparam int CW  = $clog2(MAXB);
  localparam int TPW = (TP_BYTES > 2) ? $clog2(TP_BYTES) : 1;
  localparam logic [CW-1:0] SYNC_END = CW'(SYNC_BITS - 1);
  localparam logic [CW-1:0] EOP_END  = CW'(EOP_BITS - 1);
  localparam logic [CW-1:0] SOF_END  = CW'(SOF_EOP_BITS - 1);

  seq_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic [7:0]     shreg_q;
  logic           last_q, sof_q, tsrc_q, pend_q, pend_sof_q, next_q;
  logic [TPW-1:0] tp_idx_q;

  logic [7:0] tp_byte;
  logic       tp_last;

  usbtx_test_pattern #(.TP_BYTES(TP_BYTES)) u_tp (
    .idx_i (tp_idx_q),
    .byte_o(tp_byte),
    .last_o(tp_last)
  );

  logic [7:0] src_byte;
  logic       src_last, go, load, eop_last, done;

  assign src_byte = tsrc_q ? tp_byte : data_i;
  assign src_last = tsrc_q ? tp_last : last_i;
  assign go       = (state_q == SQ_IDLE) && !hold_i && gap_ok_i &&
                    (test_pkt_i || start_i || pend_q);
  assign eop_last = (cnt_q == (sof_q ? SOF_END : EOP_END));
  // Byte taken at preamble end or at end of a non-final byte (R8)
  assign load     = adv_i && (((state_q == SQ_SYNC) && (cnt_q == SYNC_END)) ||
                              ((state_q == SQ_DATA) && (cnt_q == 3'd7) && !last_q));
  assign done     = adv_i && (state_q == SQ_EOP) && eop_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SQ_IDLE;
      cnt_q      <= '0;
      shreg_q    <= '0;
      last_q     <= 1'b0;
      sof_q      <= 1'b0;
      tsrc_q     <= 1'b0;
      pend_q     <= 1'b0;
      pend_sof_q <= 1'b0;
      next_q     <= 1'b0;
      tp_idx_q   <= '0;
    end else begin
      next_q <= load && !tsrc_q;

      if (hold_i || test_pkt_i) begin
        pend_q <= 1'b0;
      end else if (go) begin
        pend_q <= 1'b0;
      end else if (start_i) begin
        pend_q     <= 1'b1;
        pend_sof_q <= sof_i;
      end

      if (hold_i) begin
        state_q <= SQ_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          SQ_IDLE: if (go) begin
            state_q  <= SQ_SYNC;
            cnt_q    <= '0;
            tsrc_q   <= test_pkt_i;
            tp_idx_q <= '0;
            sof_q    <= !test_pkt_i && (pend_q ? pend_sof_q : sof_i);
          end
          SQ_SYNC: if (adv_i) begin
            if (cnt_q == SYNC_END) begin
              state_q  <= SQ_DATA;
              cnt_q    <= '0;
              shreg_q  <= src_byte;
              last_q   <= src_last;
              tp_idx_q <= tp_idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          SQ_DATA: if (adv_i) begin
            if (cnt_q == 3'd7) begin
              cnt_q <= '0;
              if (last_q) begin
                state_q <= SQ_EOP;
              end else begin
                shreg_q  <= src_byte;
                last_q   <= src_last;
                tp_idx_q <= tp_idx_q + 1'b1;
              end
            end else begin
              shreg_q <= {1'b0, shreg_q[7:1]};
              cnt_q   <= cnt_q + 1'b1;
            end
          end
          SQ_EOP: if (adv_i) begin
            if (eop_last) begin
              state_q <= SQ_IDLE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= SQ_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      SQ_SYNC: bit_o = (cnt_q == SYNC_END);  // R1: 31 zeros then a one
      SQ_DATA: bit_o = shreg_q[0];           // R2: LSB first
      SQ_EOP:  bit_o = 1'b1;                 // R4: unchanged level
      default: bit_o = 1'b0;
    endcase
  end

  assign valid_o    = (state_q != SQ_IDLE);
  assign stuff_en_o = (state_q != SQ_EOP);
  assign next_o     = next_q;
  assign gap_kick_o = done && tsrc_q;

endmodule

// File: rtl/usbtx_nrzi_encoder.sv
module usbtx_nrzi_encoder #(
  parameter int STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic force_j_i,
  input  logic force_k_i,
  input  logic valid_i,
  input  logic bit_i,
  input  logic stuff_en_i,
  output logic adv_o,
  output logic line_k_o,
  output logic line_oe_o
);
  localparam int SW = $clog2(STUFF_RUN + 1);
  localparam logic [SW-1:0] RUN = SW'(STUFF_RUN);

  logic [SW-1:0] ones_q;
  logic          k_q, oe_q, stuff_now;

  // A pending stuff bit is inserted before whatever bit comes next (R3)
  assign stuff_now = valid_i && (ones_q == RUN);
  assign adv_o     = valid_i && !stuff_now && !force_j_i && !force_k_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q    <= 1'b0;
      oe_q   <= 1'b0;
      ones_q <= '0;
    end else if (force_j_i || force_k_i) begin
      oe_q   <= 1'b1;
      k_q    <= force_k_i;
      ones_q <= '0;
    end else if (!valid_i) begin
      oe_q   <= 1'b0;
      k_q    <= 1'b0;   // R5: idle, J reference for the next preamble
      ones_q <= '0;
    end else begin
      oe_q <= 1'b1;
      if (stuff_now || !bit_i) begin
        k_q    <= ~k_q;
        ones_q <= '0;
      end else if (stuff_en_i) begin
        ones_q <= ones_q + 1'b1;
      end
    end
  end

  assign line_k_o  = k_q;
  assign line_oe_o = oe_q;

endmodule

// File: rtl/usbtx_framer.sv
module usbtx_framer
  import usbtx_pkg::*;
#(
  parameter int GAP_MIN      = 8,
  parameter int EOP_BITS     = 8,
  parameter int SOF_EOP_BITS = 40,
  parameter int STUFF_RUN    = 6,
  parameter int TP_BYTES     = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_i,
  input  logic       rx_end_i,
  input  logic       tx_start_i,
  input  logic       tx_sof_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_last_i,
  output logic       tx_next_o,
  output logic       line_k_o,
  output logic       line_oe_o
);
  tx_mode_e mode;
  assign mode = tx_mode_e'(mode_i);

  logic force_j, force_k, test_pkt, hold;
  assign force_j  = (mode == MODE_TEST_J);
  assign force_k  = (mode == MODE_TEST_K);
  assign test_pkt = (mode == MODE_TEST_PKT);
  assign hold     = force_j || force_k;

  logic gap_ok, gap_kick, adv, seq_bit, seq_valid, seq_stuff_en;

  usbtx_gap_timer #(.GAP_MIN(GAP_MIN)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .restart_i(rx_end_i || gap_kick),
    .gap_ok_o (gap_ok)
  );

  usbtx_sequencer #(
    .EOP_BITS    (EOP_BITS),
    .SOF_EOP_BITS(SOF_EOP_BITS),
    .TP_BYTES    (TP_BYTES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .hold_i    (hold),
    .test_pkt_i(test_pkt),
    .start_i   (tx_start_i),
    .sof_i     (tx_sof_i),
    .data_i    (tx_data_i),
    .last_i    (tx_last_i),
    .gap_ok_i  (gap_ok),
    .adv_i     (adv),
    .bit_o     (seq_bit),
    .valid_o   (seq_valid),
    .stuff_en_o(seq_stuff_en),
    .next_o    (tx_next_o),
    .gap_kick_o(gap_kick)
  );

  usbtx_nrzi_encoder #(.STUFF_RUN(STUFF_RUN)) u_enc (
    .clk       (clk),
    .rst       (rst),
    .force_j_i (force_j),
    .force_k_i (force_k),
    .valid_i   (seq_valid),
    .bit_i     (seq_bit),
    .stuff_en_i(seq_stuff_en),
    .adv_o     (adv),
    .line_k_o  (line_k_o),
    .line_oe_o (line_oe_o)
  );

endmodule

// File: rtl/usbtx_framer_chk.sv
module usbtx_framer_chk
  import usbtx_pkg::*;
#(
  parameter int GAP_MIN = 8
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode_i,
  input logic       rx_end_i,
  input logic       tx_next_o,
  input logic       line_k_o,
  input logic       line_oe_o
);
  localparam int GW = $clog2(GAP_MIN + 3);
  localparam logic [GW-1:0] GSAT = GW'(GAP_MIN + 2);

  logic [GW-1:0] since_rx_q;
  logic          forced;
  assign forced = (mode_i == MODE_TEST_J) || (mode_i == MODE_TEST_K);

  always_ff @(posedge clk) begin
    if (rst)                     since_rx_q <= GSAT;
    else if (rx_end_i)           since_rx_q <= '0;
    else if (since_rx_q != GSAT) since_rx_q <= since_rx_q + 1'b1;
  end

  p_sync_first_k_r1: assert property (@(posedge clk) disable iff (rst)
    ($rose(line_oe_o) && !forced) |-> line_k_o);

  p_idle_level_r5: assert property (@(posedge clk) disable iff (rst)
    !line_oe_o |-> !line_k_o);

  p_turnaround_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(line_oe_o) && !forced) |-> (since_rx_q >= GSAT));

  p_next_single_r8: assert property (@(posedge clk) disable iff (rst)
    tx_next_o |=> !tx_next_o);

  p_test_j_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_TEST_J) |=> ((mode_i != MODE_TEST_J) || (line_oe_o && !line_k_o)));

  p_test_k_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_TEST_K) |=> ((mode_i != MODE_TEST_K) || (line_oe_o && line_k_o)));

endmodule

bind usbtx_framer usbtx_framer_chk #(.GAP_MIN(GAP_MIN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_i   (mode_i),
  .rx_end_i (rx_end_i),
  .tx_next_o(tx_next_o),
  .line_k_o (line_k_o),
  .line_oe_o(line_oe_o)
);

// File: tb/sim_usbtx_framer.sv
module sim_usbtx_framer;
  localparam int GAP  = 8;
  localparam int EOPB = 8;
  localparam int SOFB = 40;
  localparam int TPB  = 4;

  logic       clk = 1'b0, rst = 1'b1;
  logic [2:0] mode = 3'd0;
  logic       rx_end = 1'b0, start = 1'b0, sof = 1'b0, last = 1'b0;
  logic [7:0] data = 8'h00;
  logic       next, k, oe;

  always #10 clk = ~clk;

  usbtx_framer #(
    .GAP_MIN(GAP), .EOP_BITS(EOPB), .SOF_EOP_BITS(SOFB),
    .STUFF_RUN(6), .TP_BYTES(TPB)
  ) u0 (
    .clk(clk), .rst(rst), .mode_i(mode), .rx_end_i(rx_end),
    .tx_start_i(start), .tx_sof_i(sof), .tx_data_i(data), .tx_last_i(last),
    .tx_next_o(next), .line_k_o(k), .line_oe_o(oe)
  );

  // {len, base, step, flags}; flags: bit0 long end field, bit1 after rx_end, bit2 SE0_NAK mode
  localparam logic [31:0] VEC [6] = '{
    32'h01_FF_00_00, 32'h03_FF_00_02, 32'h04_00_00_00,
    32'h05_3F_40_00, 32'h06_C3_11_01, 32'h02_7E_81_06
  };

  int total = 0, bad = 0;
  bit fin = 0;
  logic [7:0] pb [0:63];
  int exp_k [0:1023];
  int exp_n;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Independent line model built from R1..R4
  task automatic build(input int nb, input int eopn);
    int lv = 0;
    int ones = 0;
    exp_n = 0;
    for (int i = 0; i < 32 + nb * 8; i++) begin
      bit b;
      if (i < 32) b = (i == 31);
      else        b = pb[(i - 32) / 8][(i - 32) % 8];
      if (ones == 6) begin
        lv = 1 - lv; ones = 0;
        exp_k[exp_n] = lv; exp_n++;
      end
      if (!b) begin lv = 1 - lv; ones = 0; end
      else ones++;
      exp_k[exp_n] = lv; exp_n++;
    end
    if (ones == 6) begin
      lv = 1 - lv;
      exp_k[exp_n] = lv; exp_n++;
    end
    for (int i = 0; i < eopn; i++) begin
      exp_k[exp_n] = lv; exp_n++;
    end
  endtask

  // Starts at a falling edge; acts as the link and records the packet
  task automatic capture(input int nb, output int lat, output int nsym,
                         output int mism, output int nnext);
    int idx = 0;
    bit seen = 0;
    lat = 0; nsym = 0; mism = 0; nnext = 0;
    for (int c = 0; c < 3000; c++) begin
      if (next) begin
        nnext++; idx++;
        if (idx < nb) begin data = pb[idx]; last = (idx == nb - 1); end
      end
      if (oe) begin
        seen = 1;
        if (nsym >= exp_n) mism++;
        else if (exp_k[nsym] != int'(k)) mism++;
        nsym++;
      end else if (seen) begin
        break;
      end else begin
        lat++;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_pkt(input bit rxe, input bit sfl, input int nb, output int lat,
                         output int nsym, output int mism, output int nnext);
    @(negedge clk);
    data = pb[0]; last = (nb == 1); sof = sfl; start = 1'b1; rx_end = rxe;
    @(negedge clk);
    start = 1'b0; rx_end = 1'b0; sof = 1'b0;
    capture(nb, lat, nsym, mism, nnext);
    lat = lat + 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat, nsym, mism, nnext, gap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5: reset state
    chk(!oe && !k && !next, "R5 reset outputs", {oe, k, next}, 0);

    for (int v = 0; v < 6; v++) begin
      logic [31:0] vec;
      int nb;
      vec = VEC[v];
      nb = int'(vec[31:24]);
      for (int i = 0; i < nb; i++) pb[i] = vec[23:16] + vec[15:8] * 8'(i);
      mode = vec[2] ? 3'd1 : 3'd0;
      build(nb, vec[0] ? SOFB : EOPB);
      run_pkt(vec[1], vec[0], nb, lat, nsym, mism, nnext);
      if (vec[1]) chk(lat == GAP + 3, "R7 turnaround start", lat, GAP + 3);
      else        chk(lat == 2, "R6 start latency", lat, 2);
      chk(nsym == exp_n, "R5 R4 symbol count", nsym, exp_n);
      chk(mism == 0, vec[2] ? "R12 framing in SE0_NAK" : "R1 R2 R3 R4 symbols", mism, 0);
      chk(nnext == nb, "R8 byte strobes", nnext, nb);
      chk(!k, "R5 idle level", int'(k), 0);
      repeat (3) @(negedge clk);
    end
    mode = 3'd0;

    // R9: Test J
    mode = 3'd2;
    @(negedge clk);
    begin
      int errs = 0;
      for (int i = 0; i < 6; i++) begin
        if (!(oe && !k)) errs++;
        @(negedge clk);
      end
      chk(errs == 0, "R9 continuous J", errs, 0);
    end
    mode = 3'd0;
    @(negedge clk); @(negedge clk);
    chk(!oe, "R5 release after J", int'(oe), 0);

    // R10: Test K
    mode = 3'd3;
    @(negedge clk);
    begin
      int errs = 0;
      for (int i = 0; i < 6; i++) begin
        if (!(oe && k)) errs++;
        @(negedge clk);
      end
      chk(errs == 0, "R10 continuous K", errs, 0);
    end
    mode = 3'd0;
    @(negedge clk); @(negedge clk);
    chk(!oe && !k, "R5 release after K", {oe, k}, 0);

    // R11: looped test packet
    for (int i = 0; i < TPB; i++) pb[i] = 8'hA5 ^ 8'(i);
    build(TPB, EOPB);
    mode = 3'd4;
    @(negedge clk);
    capture(TPB, lat, nsym, mism, nnext);
    chk(mism == 0 && nsym == exp_n, "R11 test packet copy 1", mism + nsym, exp_n);
    chk(nnext == 0, "R11 no byte strobes", nnext, 0);
    gap = 1;
    for (int c = 0; c < 100 && !oe; c++) begin
      @(negedge clk);
      if (!oe) gap++;
    end
    chk(gap == GAP + 1, "R11 gap between copies", gap, GAP + 1);
    capture(TPB, lat, nsym, mism, nnext);
    chk(mism == 0 && nsym == exp_n, "R11 test packet copy 2", mism + nsym, exp_n);
    mode = 3'd0;
    for (int c = 0; c < 300 && oe; c++) @(negedge clk);
    repeat (GAP + 4) @(negedge clk);
    chk(!oe, "R11 loop stops in normal mode", int'(oe), 0);

    // R5: reset in the middle of a packet
    pb[0] = 8'h00;
    @(negedge clk);
    data = 8'h00; last = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!oe && !k, "R5 reset mid packet", {oe, k}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(!oe, "R5 stays idle after reset", int'(oe), 0);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule